// File: doc/BRIEF.md
# Crossbar Cell Scheduler (two-round iSLIP with multicast fan-out)

This block is the central arbiter of an N-port cell crossbar. Each input line card keeps a virtual output queue for every destination, split into a high and a low priority class. Every cycle it presents one request bit per destination and class. The scheduler turns these into a conflict-free crossbar setting. At every cell boundary, marked by a one-cycle `cell_tick`, it captures that setting.

Unicast matching uses round-robin request-grant-accept (iSLIP). It runs exactly two rounds per class inside the cell time. High priority is matched first. Low priority then only sees the inputs and outputs that high priority left free. Each output keeps a grant pointer and each input keeps an accept pointer, one set per class. A pointer moves only when a grant is accepted in the first round.

Multicast runs alongside unicast. An input loads a fan-out mask and is granted whatever outputs unicast left free. Outputs that could not be served stay pending for later cells.

Top module: `xbar_cell_sched`

## Requirements
- R1: While reset is asserted and after it is released, `uc_match`, `mc_grant` and `mc_pending` are all zero. All grant and accept pointers start at port 0.
- R2: In `uc_match`, bit i*N+j set means input i is connected to output j. Each input row has at most one bit set, and each output is used by at most one input.
- R3: No output is used both by a unicast match and by a multicast grant. No output is granted to two multicast inputs.
- R4: A unicast match (i,j) exists only if `hi_req` or `lo_req` bit i*N+j was set when the result was captured.
- R5: High-priority requests are matched first. Low-priority matching uses only inputs and outputs left unmatched by high-priority traffic.
- R6: A grant pointer moves to one past the input it granted, and the accept pointer moves to one past the accepted output. This happens only for matches made in the first round, and pointers wrap from N-1 to 0. Matches made in the second round leave the pointers unchanged.
- R7: Each class runs exactly two request-grant-accept rounds per cell. Example with N=4, all high requests set and pointers at 0: the result is input 0 to output 0 and input 1 to output 1 only.
- R8: Results are computed from the inputs present at a clock edge where `cell_tick` is high, and are registered at that edge. Between ticks, all outputs hold their values.
- R9: A multicast input gets the outputs in its fan-out (`mc_fanout` bit i*N+j means output j) that are still free after unicast matching. Lower input indices are served first. The unserved bits go to `mc_pending` row i.
- R10: While `mc_pending` row i is non-zero, `mc_load[i]` and its fan-out are ignored. The pending bits are served in later cells and only ever shrink.
- R11: An input that received a unicast match in a cell gets no multicast grant in that cell, and its whole fan-out stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cell_tick | input | 1 | Cell boundary strobe; results are captured at this edge |
| hi_req | input | N*N | High-priority unicast requests, bit i*N+j is input i to output j |
| lo_req | input | N*N | Low-priority unicast requests, same encoding |
| mc_load | input | N | Offer a new multicast fan-out for input i |
| mc_fanout | input | N*N | Multicast fan-out masks, row i is for input i |
| uc_match | output | N*N | Registered unicast crossbar setting, one-hot rows |
| mc_grant | output | N*N | Registered multicast grants, row i is for input i |
| mc_pending | output | N*N | Multicast fan-out bits still waiting, row i is for input i |

## Verification
All three outputs are due at the rising edge where `cell_tick` is sampled high. The bench drives the requests and the tick on a falling edge and drops the tick at the next falling edge. It then compares the outputs at that falling edge, one edge after the capture, against a bench model of the pointers and residual masks. For R8, the bench changes the requests for several cycles with the tick low and checks that every output still equals the last captured value. Each directed case starts from reset, so the pointer values behind R6 and R7 are known.

// File: rtl/xbs_pkg.sv
package xbs_pkg;

   // width of a port index, never below one bit
   function automatic int ptr_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // round-robin successor of a port index
   function automatic int step(input int v, input int n);
      return (v + 1 >= n) ? 0 : v + 1;
   endfunction

endpackage

// File: rtl/xbs_rr_pick.sv
module xbs_rr_pick #(
   parameter int N = 4,
   localparam int PW = xbs_pkg::ptr_w(N)
) (
   input  logic [N-1:0]  req,
   input  logic [PW-1:0] ptr,
   output logic [N-1:0]  gnt
);

   if (N < 2) begin : g_chk
      $error("xbs_rr_pick: N must be at least 2");
   end

   always_comb begin
      logic found;
      int   idx;
      gnt   = '0;
      found = 1'b0;
      for (int k = 0; k < N; k++) begin
         idx = (int'(ptr) + k) % N;
         if (!found && req[idx]) begin
            gnt[idx] = 1'b1;
            found    = 1'b1;
         end
      end
   end

endmodule

// File: rtl/xbs_islip_level.sv
module xbs_islip_level #(
   parameter int N = 4,
   localparam int PW = xbs_pkg::ptr_w(N),
   localparam int NN = N * N
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cell_tick,
   input  logic [NN-1:0] req,
   input  logic [N-1:0]  in_busy,
   input  logic [N-1:0]  out_busy,
   output logic [NN-1:0] match
);

   logic [PW-1:0] gptr [N];
   logic [PW-1:0] aptr [N];

   // c*: per output, eligible inputs; g*: per output, granted input
   // r*: per input, outputs granting it; a*: per input, accepted output
   logic [N-1:0] c1 [N];
   logic [N-1:0] g1 [N];
   logic [N-1:0] r1 [N];
   logic [N-1:0] a1 [N];
   logic [N-1:0] c2 [N];
   logic [N-1:0] g2 [N];
   logic [N-1:0] r2 [N];
   logic [N-1:0] a2 [N];
   logic [N-1:0] in_m1;
   logic [N-1:0] out_m1;

   // round one request matrix, transposed to per-output columns
   always_comb begin
      for (int j = 0; j < N; j++) begin
         for (int i = 0; i < N; i++) begin
            c1[j][i] = req[i*N+j] & ~in_busy[i] & ~out_busy[j];
         end
      end
   end

   for (genvar p = 0; p < N; p++) begin : g_arb
      xbs_rr_pick #(.N(N)) i_grant1  (.req(c1[p]), .ptr(gptr[p]), .gnt(g1[p]));
      xbs_rr_pick #(.N(N)) i_accept1 (.req(r1[p]), .ptr(aptr[p]), .gnt(a1[p]));
      xbs_rr_pick #(.N(N)) i_grant2  (.req(c2[p]), .ptr(gptr[p]), .gnt(g2[p]));
      xbs_rr_pick #(.N(N)) i_accept2 (.req(r2[p]), .ptr(aptr[p]), .gnt(a2[p]));
   end

   // grants seen by inputs in round one, and the ports it consumed
   always_comb begin
      out_m1 = '0;
      for (int i = 0; i < N; i++) begin
         for (int j = 0; j < N; j++) begin
            r1[i][j] = g1[j][i];
         end
         in_m1[i] = |a1[i];
         out_m1   = out_m1 | a1[i];
      end
   end

   // round two works only on ports still free after round one
   always_comb begin
      for (int j = 0; j < N; j++) begin
         for (int i = 0; i < N; i++) begin
            c2[j][i] = c1[j][i] & ~in_m1[i] & ~out_m1[j];
         end
      end
   end

   always_comb begin
      for (int i = 0; i < N; i++) begin
         for (int j = 0; j < N; j++) begin
            r2[i][j]     = g2[j][i];
            match[i*N+j] = a1[i][j] | a2[i][j];
         end
      end
   end

   // pointers move only for round-one matches
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int p = 0; p < N; p++) begin
            gptr[p] <= '0;
            aptr[p] <= '0;
         end
      end else if (cell_tick) begin
         for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
               if (a1[i][j]) begin
                  gptr[j] <= PW'(xbs_pkg::step(i, N));
                  aptr[i] <= PW'(xbs_pkg::step(j, N));
               end
            end
         end
      end
   end

   for (genvar p = 0; p < N; p++) begin : g_chk_busy
      AST_BUSY_INPUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         in_busy[p] |-> (match[p*N +: N] == '0))
         else $error("busy input matched at lower class"); // R5
   end

endmodule

// File: rtl/xbs_mcast.sv
module xbs_mcast #(
   parameter int N = 4,
   localparam int NN = N * N
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cell_tick,
   input  logic [N-1:0]  mc_load,
   input  logic [NN-1:0] mc_fanout,
   input  logic [N-1:0]  in_taken,
   input  logic [N-1:0]  out_taken,
   output logic [NN-1:0] serve,
   output logic [NN-1:0] pending
);

   logic [N-1:0] res [N];
   logic [N-1:0] eff [N];
   logic [N-1:0] srv [N];

   // residual fan-out wins over a newly offered one
   always_comb begin
      logic [N-1:0] avail;
      avail = ~out_taken;
      for (int i = 0; i < N; i++) begin
         if (res[i] != '0)
            eff[i] = res[i];
         else if (mc_load[i])
            eff[i] = mc_fanout[i*N +: N];
         else
            eff[i] = '0;
         srv[i] = in_taken[i] ? '0 : (eff[i] & avail);
         avail  = avail & ~srv[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) res[i] <= '0;
      end else if (cell_tick) begin
         for (int i = 0; i < N; i++) res[i] <= eff[i] & ~srv[i];
      end
   end

   always_comb begin
      for (int i = 0; i < N; i++) begin
         serve[i*N +: N]   = srv[i];
         pending[i*N +: N] = res[i];
      end
   end

   for (genvar p = 0; p < N; p++) begin : g_chk_mc
      AST_PENDING_ONLY_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
         (cell_tick && res[p] != '0) |=> ((res[p] & ~$past(res[p])) == '0))
         else $error("pending fan-out grew"); // R10
      AST_SERVED_NOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
         cell_tick |=> ((res[p] & $past(srv[p])) == '0))
         else $error("served output left pending"); // R9
   end

endmodule

// File: rtl/xbar_cell_sched.sv
module xbar_cell_sched #(
   parameter int N_PORTS = 4,
   parameter bit MC_EN   = 1'b1,
   localparam int NN = N_PORTS * N_PORTS
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cell_tick,
   input  logic [NN-1:0] hi_req,
   input  logic [NN-1:0] lo_req,
   input  logic [N_PORTS-1:0] mc_load,
   input  logic [NN-1:0] mc_fanout,
   output logic [NN-1:0] uc_match,
   output logic [NN-1:0] mc_grant,
   output logic [NN-1:0] mc_pending
);

   localparam int N = N_PORTS;

   if (N_PORTS < 2) begin : g_chk_n
      $error("xbar_cell_sched: N_PORTS must be at least 2");
   end

   logic [NN-1:0] hi_m, lo_m, uc_next, mc_next, mc_pend_w;
   logic [N-1:0]  hi_in, hi_out, uc_in, uc_out;
   logic [NN-1:0] uc_q, mc_q;

   xbs_islip_level #(.N(N)) i_hi (
      .clk(clk), .rst_n(rst_n), .cell_tick(cell_tick),
      .req(hi_req), .in_busy('0), .out_busy('0), .match(hi_m)
   );

   always_comb begin
      hi_out = '0;
      for (int i = 0; i < N; i++) begin
         hi_in[i] = |hi_m[i*N +: N];
         hi_out   = hi_out | hi_m[i*N +: N];
      end
   end

   xbs_islip_level #(.N(N)) i_lo (
      .clk(clk), .rst_n(rst_n), .cell_tick(cell_tick),
      .req(lo_req), .in_busy(hi_in), .out_busy(hi_out), .match(lo_m)
   );

   always_comb begin
      uc_next = hi_m | lo_m;
      uc_out  = '0;
      for (int i = 0; i < N; i++) begin
         uc_in[i] = |uc_next[i*N +: N];
         uc_out   = uc_out | uc_next[i*N +: N];
      end
   end

   if (MC_EN) begin : g_mc
      xbs_mcast #(.N(N)) i_mc (
         .clk(clk), .rst_n(rst_n), .cell_tick(cell_tick),
         .mc_load(mc_load), .mc_fanout(mc_fanout),
         .in_taken(uc_in), .out_taken(uc_out),
         .serve(mc_next), .pending(mc_pend_w)
      );
   end else begin : g_no_mc
      assign mc_next   = '0;
      assign mc_pend_w = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         uc_q <= '0;
         mc_q <= '0;
      end else if (cell_tick) begin
         uc_q <= uc_next;
         mc_q <= mc_next;
      end
   end

   assign uc_match   = uc_q;
   assign mc_grant   = mc_q;
   assign mc_pending = mc_pend_w;

   // per-output columns of the registered result
   logic [N-1:0] uc_col [N];
   logic [N-1:0] mc_col [N];
   always_comb begin
      for (int j = 0; j < N; j++) begin
         for (int i = 0; i < N; i++) begin
            uc_col[j][i] = uc_match[i*N+j];
            mc_col[j][i] = mc_grant[i*N+j];
         end
      end
   end

   for (genvar p = 0; p < N; p++) begin : g_chk_xbar
      AST_ROW_ONE_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(uc_match[p*N +: N])) else $error("input row not one-hot"); // R2
      AST_COL_ONE_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(uc_col[p])) else $error("output used twice"); // R2
      AST_OUTPUT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
         $countones({uc_col[p], mc_col[p]}) <= 1) else $error("output shared"); // R3
   end

   AST_MATCH_WAS_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
      cell_tick |=> ((uc_match & ~($past(hi_req) | $past(lo_req))) == '0))
      else $error("match without request"); // R4

   AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
      !cell_tick |=> ($stable(uc_match) && $stable(mc_grant) && $stable(mc_pending)))
      else $error("output moved without tick"); // R8

endmodule

// File: tb/test_xbar_cell_sched.sv
module test_xbar_cell_sched;

   localparam int CLK_PERIOD = 10;
   localparam int NP = 4;
   localparam int PB = 2;
   localparam int NN = NP * NP;
   localparam int WATCHDOG = 100000;

   logic clk = 1'b0;
   logic rst_n;
   logic cell_tick;
   logic [NN-1:0] hi_req, lo_req, mc_fanout;
   logic [NP-1:0] mc_load;
   logic [NN-1:0] uc_match, mc_grant, mc_pending;

   int total = 0;
   int bad = 0;

   // bench model state
   logic [NP*PB-1:0] gp_h, ap_h, gp_l, ap_l;
   logic [NN-1:0] m_res;
   logic [NN-1:0] exp_uc, exp_mcg, exp_pend;

   always #(CLK_PERIOD/2) clk = ~clk;

   xbar_cell_sched #(.N_PORTS(NP)) i_xbar_cell_sched (
      .clk(clk), .rst_n(rst_n), .cell_tick(cell_tick),
      .hi_req(hi_req), .lo_req(lo_req), .mc_load(mc_load), .mc_fanout(mc_fanout),
      .uc_match(uc_match), .mc_grant(mc_grant), .mc_pending(mc_pending)
   );

   task automatic check(input string tag, input logic [NN-1:0] act, input logic [NN-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_bit(input string tag, input bit ok);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=0 expected=1 (uc=%h mc=%h)", tag, uc_match, mc_grant);
      end
   endtask

   // one priority class: two rounds of request, grant, accept
   task automatic model_level(input logic [NN-1:0] req, input logic [NP-1:0] ib,
                              input logic [NP-1:0] ob,
                              inout logic [NP*PB-1:0] gp, inout logic [NP*PB-1:0] ap,
                              output logic [NN-1:0] m);
      logic [NP-1:0] inm, outm;
      logic [NP*PB-1:0] gp0, ap0;
      int gsel [NP];
      m = '0; inm = ib; outm = ob; gp0 = gp; ap0 = ap;
      for (int it = 0; it < 2; it++) begin
         for (int j = 0; j < NP; j++) begin
            gsel[j] = -1;
            if (!outm[j]) begin
               for (int k = 0; k < NP; k++) begin
                  int i;
                  i = (int'(gp0[j*PB +: PB]) + k) % NP;
                  if (gsel[j] < 0 && req[i*NP+j] && !inm[i]) gsel[j] = i;
               end
            end
         end
         for (int i = 0; i < NP; i++) begin
            int acc;
            acc = -1;
            if (!inm[i]) begin
               for (int k = 0; k < NP; k++) begin
                  int j;
                  j = (int'(ap0[i*PB +: PB]) + k) % NP;
                  if (acc < 0 && gsel[j] == i) acc = j;
               end
            end
            if (acc >= 0) begin
               m[i*NP+acc] = 1'b1;
               inm[i] = 1'b1;
               outm[acc] = 1'b1;
               if (it == 0) begin
                  gp[acc*PB +: PB] = PB'((i + 1) % NP);
                  ap[i*PB +: PB]   = PB'((acc + 1) % NP);
               end
            end
         end
      end
   endtask

   task automatic model_cell(input logic [NN-1:0] h, input logic [NN-1:0] l,
                             input logic [NP-1:0] ld, input logic [NN-1:0] fan);
      logic [NN-1:0] mh, ml;
      logic [NP-1:0] hin, hout, uin, uout, avail, eff, srv;
      model_level(h, '0, '0, gp_h, ap_h, mh);
      hin = '0; hout = '0;
      for (int i = 0; i < NP; i++) begin
         hin[i] = |mh[i*NP +: NP];
         hout = hout | mh[i*NP +: NP];
      end
      model_level(l, hin, hout, gp_l, ap_l, ml);
      exp_uc = mh | ml;
      uin = '0; uout = '0;
      for (int i = 0; i < NP; i++) begin
         uin[i] = |exp_uc[i*NP +: NP];
         uout = uout | exp_uc[i*NP +: NP];
      end
      avail = ~uout;
      exp_mcg = '0;
      for (int i = 0; i < NP; i++) begin
         eff = (m_res[i*NP +: NP] != '0) ? m_res[i*NP +: NP] :
               (ld[i] ? fan[i*NP +: NP] : '0);
         srv = uin[i] ? '0 : (eff & avail);
         avail = avail & ~srv;
         exp_mcg[i*NP +: NP] = srv;
         m_res[i*NP +: NP] = eff & ~srv;
      end
      exp_pend = m_res;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; cell_tick = 1'b0;
      hi_req = '0; lo_req = '0; mc_load = '0; mc_fanout = '0;
      gp_h = '0; ap_h = '0; gp_l = '0; ap_l = '0; m_res = '0;
      exp_uc = '0; exp_mcg = '0; exp_pend = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // drive one cell, outputs are checked one falling edge later
   task automatic run_cell(input logic [NN-1:0] h, input logic [NN-1:0] l,
                           input logic [NP-1:0] ld, input logic [NN-1:0] fan);
      @(negedge clk);
      hi_req = h; lo_req = l; mc_load = ld; mc_fanout = fan; cell_tick = 1'b1;
      model_cell(h, l, ld, fan);
      @(negedge clk);
      cell_tick = 1'b0;
   endtask

   task automatic check_props(input logic [NN-1:0] h, input logic [NN-1:0] l);
      logic [NP-1:0] cu, cm;
      bit rows_ok, cols_ok, excl_ok;
      rows_ok = 1; cols_ok = 1; excl_ok = 1;
      for (int i = 0; i < NP; i++)
         if ($countones(uc_match[i*NP +: NP]) > 1) rows_ok = 0;
      for (int j = 0; j < NP; j++) begin
         for (int i = 0; i < NP; i++) begin
            cu[i] = uc_match[i*NP+j];
            cm[i] = mc_grant[i*NP+j];
         end
         if ($countones(cu) > 1) cols_ok = 0;
         if ($countones(cu) + $countones(cm) > 1) excl_ok = 0;
      end
      check_bit("R2 one-hot rows and columns", rows_ok && cols_ok);
      check_bit("R3 output exclusive", excl_ok);
      check_bit("R4 match requested", (uc_match & ~(h | l)) == '0);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd5813));

      // R1: reset state
      rst_n = 1'b0; cell_tick = 1'b0;
      hi_req = '1; lo_req = '1; mc_load = '1; mc_fanout = '1;
      repeat (3) @(negedge clk);
      check("R1 uc in reset", uc_match, '0);
      check("R1 mc in reset", mc_grant, '0);
      do_reset();
      check("R1 uc after reset", uc_match, '0);
      check("R1 pending after reset", mc_pending, '0);

      // R7: full request matrix, only two rounds
      run_cell('1, '0, '0, '0);
      check("R7 two rounds", uc_match, 16'h0021);
      // R6: round-two match did not move its pointers
      run_cell('1, '0, '0, '0);
      check("R6 pointer rule", uc_match, 16'h0412);

      // R6: two inputs contending for output 0
      do_reset();
      run_cell(16'h0011, '0, '0, '0);
      check("R6 rr first", uc_match, 16'h0001);
      run_cell(16'h0011, '0, '0, '0);
      check("R6 rr second", uc_match, 16'h0010);
      run_cell(16'h0011, '0, '0, '0);
      check("R6 rr wrap", uc_match, 16'h0001);

      // R8: no tick, outputs hold despite new requests
      hi_req = 16'hFFFF; lo_req = 16'hFFFF;
      repeat (3) @(negedge clk);
      check("R8 hold uc", uc_match, 16'h0001);
      check("R8 hold pending", mc_pending, '0);

      // R5: high claims input 0, low cannot reuse it or output 1
      do_reset();
      run_cell(16'h0002, 16'h0021, '0, '0);
      check("R5 strict priority", uc_match, 16'h0002);

      // R9 / R10 / R11: multicast
      do_reset();
      run_cell(16'h4210, '0, 4'b0001, 16'h000F);
      check("R9 mc uses free output", mc_grant, 16'h0008);
      check("R9 mc remainder", mc_pending, 16'h0007);
      check("R9 uc alongside", uc_match, 16'h4210);
      run_cell('0, '0, 4'b0001, 16'h0008);
      check("R10 load ignored, residual served", mc_grant, 16'h0007);
      check("R10 residual cleared", mc_pending, '0);
      run_cell(16'h0001, '0, 4'b0001, 16'h0006);
      check("R11 unicast blocks mc", mc_grant, '0);
      check("R11 fan-out pending", mc_pending, 16'h0006);
      run_cell('0, '0, 4'b0011, 16'h0079);
      check("R9 lower input first", mc_grant, 16'h0016);
      check("R10 pending after split", mc_pending, 16'h0060);

      // random cells against the model
      do_reset();
      for (int n = 0; n < 400; n++) begin
         logic [NN-1:0] h, l, f;
         logic [NP-1:0] ld;
         h  = NN'($urandom & $urandom);
         l  = NN'($urandom);
         f  = NN'($urandom);
         ld = NP'($urandom);
         run_cell(h, l, ld, f);
         check("R5 R6 R7 unicast", uc_match, exp_uc);
         check("R9 R11 mc grant", mc_grant, exp_mcg);
         check("R10 mc pending", mc_pending, exp_pend);
         check_props(h, l);
         if (n % 50 == 7) begin
            @(negedge clk);
            hi_req = NN'($urandom);
            @(negedge clk);
            check("R8 hold random", uc_match, exp_uc);
         end
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule